// File: doc/BRIEF.md
# Timer Interrupt Flag/Mask Controller

This block collects the event pulses of an eight-channel timer unit and turns them into interrupt requests. Each channel has an event flag. A one-cycle pulse from the channel sets the flag. The flag then stays set until software clears it. Each channel also has a mask bit, where 1 blocks the channel. A channel is pending when its flag is set and its mask bit is 0.

Software never writes the flag or mask state directly. It sends one-hot strobes to three write-only addresses: one sets mask bits, one clears mask bits, and one clears flags. Because of this, a read-modify-write race cannot corrupt a neighbouring bit. Flag and mask state can be read back at two read-only addresses.

Pending channels are merged onto a few level-sensitive parent lines. A parameter chooses one of two channel-to-line maps. The block sits between the timer counters and the system interrupt controller.

Top module: `tmr_irq_agg`

## Requirements
- R1: After reset, every flag reads 0, every mask bit of an implemented channel reads 1, and all parent lines are low.
- R2: A one-cycle pulse on `evt_pulse[i]` sets flag i from the next clock edge on. The flag stays set after the pulse ends, until a flag-clear write removes it.
- R3: A write to address 2 (mask set) sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to address 3 (mask clear) clears every mask bit whose data bit is 1, which enables those channels. Mask bits whose data bit is 0 keep their value.
- R5: A write to address 4 (flag clear) clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: If an event pulse and a flag-clear write hit the same bit in the same cycle, the flag ends up set.
- R7: A parent line is high exactly while at least one channel routed to it has its flag set and its mask bit 0. A masked flag stays readable but does not raise any line.
- R8: With `ROUTE_MODE` = 0, line 0 carries channel 0, line 1 carries channel 1, and line 2 carries channels 2 to 7.
- R9: With `ROUTE_MODE` = 1, line 1 carries only channel 5, line 0 carries channels 0 to 4 and 6 to 7, and line 2 stays low.
- R10: Address 0 reads the flags and address 1 reads the mask, with channel i at data bit i. Bits above the channel count read 0, and every other address reads 0. Writes to addresses 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pulse | input | 8 | One-cycle event pulse per timer channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address (reads and writes) |
| wdata | input | 32 | Write data, bit i selects channel i |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_line | output | 3 | Level-sensitive parent interrupt lines |

## Verification
The bench targets the cycle in which an event pulse and a flag-clear strobe hit the same bit. A design that lets the clear win drops that event, and the flag reads 0. It also checks strobes that carry zero bits next to one bits. A design that wrote the register instead of merging the strobe would wipe the neighbouring mask bits or flags. Both routing maps are driven with the same stimulus, so swapping channel 5 or the low pair onto the wrong line shows up as a wrong parent-line pattern. Finally, writes to the read-only addresses and reads of unused addresses confirm that no hidden write path exists and that unused bits read as zero.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  localparam int AW = 4;

  typedef enum logic [AW-1:0] {
    REG_FLAG_RD = 4'd0,
    REG_MASK_RD = 4'd1,
    REG_MSET    = 4'd2,
    REG_MCLR    = 4'd3,
    REG_FCLR    = 4'd4
  } reg_addr_e;

  // Parent line that channel ch drives under the given routing mode.
  function automatic int route_of(input int mode, input int ch);
    if (mode == 0) begin
      return (ch < 2) ? ch : 2;
    end
    return (ch == 5) ? 1 : 0;
  endfunction

  // Channel select vector of one parent line.
  function automatic logic [31:0] line_sel(input int mode, input int line, input int nch);
    logic [31:0] v;
    v = '0;
    for (int c = 0; c < nch; c++) begin
      if (route_of(mode, c) == line) v[c] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/tmr_irq_rst_sync.sv
module tmr_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/tmr_irq_reg_dec.sv
module tmr_irq_reg_dec
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] flag,
  input  logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] mset,
  output logic [NUM_CH-1:0] mclr,
  output logic [NUM_CH-1:0] fclr,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - NUM_CH;

  logic [NUM_CH-1:0] wbits;
  logic              unused_hi;

  assign wbits     = wdata[NUM_CH-1:0];
  assign unused_hi = ^wdata[DATA_W-1:NUM_CH];

  // Strobe decode: only the three write-only addresses have an effect.
  always_comb begin
    mset = '0;
    mclr = '0;
    fclr = '0;
    if (wr_en) begin
      case (addr)
        REG_MSET: mset = wbits;
        REG_MCLR: mclr = wbits;
        REG_FCLR: fclr = wbits;
        default: ;
      endcase
    end
  end

  // Read mux.
  always_comb begin
    case (addr)
      REG_FLAG_RD: rdata = {{PAD_W{1'b0}}, flag};
      REG_MASK_RD: rdata = {{PAD_W{1'b0}}, mask};
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_irq_flag_bank.sv
module tmr_irq_flag_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] flag_q
);

  logic [NUM_CH-1:0] flag_nxt;
  logic              flag_en;

  // Set after clear: an event in the clearing cycle survives.
  always_comb begin
    flag_en  = (|evt) | (|clr);
    flag_nxt = (flag_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_nxt;
  end

endmodule

// File: rtl/tmr_irq_mask_bank.sv
module tmr_irq_mask_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] mask_q
);

  logic [NUM_CH-1:0] mask_nxt;
  logic              mask_en;

  always_comb begin
    mask_en  = (|set) | (|clr);
    mask_nxt = (mask_q | set) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_nxt;
  end

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_LINES  = 3,
  parameter int ROUTE_MODE = 0
) (
  input  logic [NUM_CH-1:0]    flag,
  input  logic [NUM_CH-1:0]    mask,
  output logic [NUM_LINES-1:0] irq
);

  logic [NUM_CH-1:0] pend;

  assign pend = flag & ~mask;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [31:0]       SEL_FULL = line_sel(ROUTE_MODE, l, NUM_CH);
    localparam logic [NUM_CH-1:0] SEL      = SEL_FULL[NUM_CH-1:0];
    assign irq[l] = |(pend & SEL);
  end

endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 3,
  parameter int ROUTE_MODE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    evt_pulse,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] irq_line
);

  logic              rst_sync_n;
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] mset_s;
  logic [NUM_CH-1:0] mclr_s;
  logic [NUM_CH-1:0] fclr_s;

  tmr_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr_irq_reg_dec #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .flag  (flag_q),
    .mask  (mask_q),
    .mset  (mset_s),
    .mclr  (mclr_s),
    .fclr  (fclr_s),
    .rdata (rdata)
  );

  tmr_irq_flag_bank #(.NUM_CH(NUM_CH)) u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (evt_pulse),
    .clr    (fclr_s),
    .flag_q (flag_q)
  );

  tmr_irq_mask_bank #(.NUM_CH(NUM_CH)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (mset_s),
    .clr    (mclr_s),
    .mask_q (mask_q)
  );

  tmr_irq_router #(
    .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_MODE(ROUTE_MODE)
  ) u_route (
    .flag (flag_q),
    .mask (mask_q),
    .irq  (irq_line)
  );

endmodule

// File: rtl/tmr_irq_agg_chk.sv
module tmr_irq_agg_chk
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 3
) (
  input logic                 clk,
  input logic                 rst_ns,
  input logic [NUM_CH-1:0]    evt,
  input logic [NUM_CH-1:0]    flag,
  input logic [NUM_CH-1:0]    mask,
  input logic [NUM_LINES-1:0] irq,
  input logic                 wr_en,
  input logic [AW-1:0]        addr,
  input logic [DATA_W-1:0]    wdata
);

  logic is_mset, is_mclr, is_fclr;
  assign is_mset = wr_en && (addr == REG_MSET);
  assign is_mclr = wr_en && (addr == REG_MCLR);
  assign is_fclr = wr_en && (addr == REG_FCLR);

  // R2 / R6: every pulsed channel reads as flagged one edge later.
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_ns)
    (|evt) |=> ((flag & $past(evt)) == $past(evt)));

  // R2: without a flag-clear strobe, no flag falls.
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    !is_fclr |=> ((flag & $past(flag)) == $past(flag)));

  // R3
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_ns)
    is_mset |=> ((mask & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));

  // R4
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_ns)
    is_mclr |=> ((mask & $past(wdata[NUM_CH-1:0])) == '0));

  // R5
  a_r5_flag_clr: assert property (@(posedge clk) disable iff (!rst_ns)
    is_fclr |=> ((flag & $past(wdata[NUM_CH-1:0]) & ~$past(evt)) == '0));

  // R7: nothing pending means all lines low.
  a_r7_quiet_lines: assert property (@(posedge clk) disable iff (!rst_ns)
    ((flag & ~mask) == '0) |-> (irq == '0));

  // R10: mask moves only through its two strobe addresses.
  a_r10_mask_no_direct: assert property (@(posedge clk) disable iff (!rst_ns)
    !(is_mset || is_mclr) |=> $stable(mask));

endmodule

bind tmr_irq_agg tmr_irq_agg_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk    (clk),
  .rst_ns (rst_sync_n),
  .evt    (evt_pulse),
  .flag   (flag_q),
  .mask   (mask_q),
  .irq    (irq_line),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata)
);

// File: tb/sim_tmr_irq_agg.sv
module sim_tmr_irq_agg;

  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int NL  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] evt_pulse = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = 4'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_a, rdata_b;
  logic [NL-1:0] irq_a, irq_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [NCH-1:0] m_flag;
  logic [NCH-1:0] m_mask;

  always #2 clk = ~clk;

  tmr_irq_agg #(.ROUTE_MODE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_a), .irq_line(irq_a)
  );

  tmr_irq_agg #(.ROUTE_MODE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_b), .irq_line(irq_b)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected lines from the requirement tables (R8, R9).
  function automatic logic [NL-1:0] exp_lines(input logic [NCH-1:0] f,
                                              input logic [NCH-1:0] m, input int mode);
    logic [NCH-1:0] p;
    logic [NL-1:0]  r;
    p = f & ~m;
    r = '0;
    if (mode == 0) begin
      r[0] = p[0];
      r[1] = p[1];
      r[2] = |p[7:2];
    end else begin
      r[1] = p[5];
      r[0] = |{p[7:6], p[4:0]};
    end
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; addr = 4'd0;
    if (a == 4'd2) m_mask = m_mask | d[NCH-1:0];
    if (a == 4'd3) m_mask = m_mask & ~d[NCH-1:0];
    if (a == 4'd4) m_flag = m_flag & ~d[NCH-1:0];
  endtask

  task automatic pulse(input logic [NCH-1:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
    m_flag = m_flag | e;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata_a, exp);
    check(req, rdata_b, exp);
  endtask

  task automatic lines_check(input string req);
    #1;
    check({req, " mode0"}, {29'd0, irq_a}, {29'd0, exp_lines(m_flag, m_mask, 0)});
    check({req, " mode1"}, {29'd0, irq_b}, {29'd0, exp_lines(m_flag, m_mask, 1)});
  endtask

  task automatic t_reset();
    m_flag = '0; m_mask = '1;
    rd_check("R1 flags", 4'd0, 32'h0);
    rd_check("R1 mask", 4'd1, 32'h0000_00FF);
    lines_check("R1 lines");
  endtask

  task automatic t_sticky();
    pulse(8'h09);
    repeat (3) @(negedge clk);
    rd_check("R2 sticky flags", 4'd0, 32'h09);
    lines_check("R7 masked no line");
  endtask

  task automatic t_mask();
    wr(4'd3, 32'h0000_0001);
    rd_check("R4 mask clear", 4'd1, 32'hFE);
    lines_check("R7 unmasked ch0");
    wr(4'd2, 32'hFFFF_FF01);
    rd_check("R3 mask set", 4'd1, 32'hFF);
    wr(4'd3, 32'h0000_0024);
    rd_check("R4 partial clear", 4'd1, 32'hDB);
    wr(4'd2, 32'h0000_0004);
    rd_check("R3 zero bits keep", 4'd1, 32'hDF);
    lines_check("R7 after mask ops");
  endtask

  task automatic t_route();
    wr(4'd4, 32'hFF);
    wr(4'd3, 32'hFF);
    lines_check("R7 all clear");
    pulse(8'h02);
    lines_check("R8 R9 ch1");
    pulse(8'h20);
    lines_check("R8 R9 ch1 ch5");
    wr(4'd4, 32'h02);
    lines_check("R8 R9 ch5 only");
    pulse(8'h80);
    wr(4'd4, 32'h20);
    lines_check("R8 R9 ch7 only");
    pulse(8'h01);
    lines_check("R8 R9 ch0 ch7");
    wr(4'd2, 32'h81);
    lines_check("R7 remasked");
  endtask

  task automatic t_flag_clear();
    pulse(8'hFF);
    wr(4'd4, 32'h0F);
    rd_check("R5 partial flag clear", 4'd0, 32'hF0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    evt_pulse = 8'h10; wr_en = 1'b1; addr = 4'd4; wdata = 32'h30;
    @(negedge clk);
    evt_pulse = '0; wr_en = 1'b0; wdata = '0;
    m_flag = (m_flag & ~8'h30) | 8'h10;
    rd_check("R6 set wins", 4'd0, 32'hD0);
    lines_check("R6 R7 lines");
  endtask

  task automatic t_reads();
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0000_0000);
    rd_check("R10 ro flags unchanged", 4'd0, {24'd0, m_flag});
    rd_check("R10 ro mask unchanged", 4'd1, {24'd0, m_mask});
    for (int a = 2; a < 16; a++) begin
      rd_check("R10 other address", a[3:0], 32'h0);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sticky();
    t_mask();
    t_route();
    t_flag_clear();
    t_collide();
    t_reads();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule